// File: doc/BRIEF.md
# Sequential Packed-Decimal Adder/Subtractor

This unit adds or subtracts two packed binary-coded-decimal operands, one decimal digit per nibble, for the decimal mode of an 8-bit processor's arithmetic path. A request is a single-cycle `start` strobe. With the strobe come the mode select, both operands and a carry-in. One clock later the unit presents the decimal result, a decimal carry-out and an overflow flag, and it marks them with a one-cycle `done` pulse. The outputs then hold until the next request.

Subtraction uses the same digit adders. The caller passes the subtrahend already bit-inverted and treats carry-in as "no borrow". Each digit cell forms a 5-bit nibble sum and decides from it whether a decimal carry left the digit. An addition digit that carried is corrected by +6. A subtraction digit that did not carry is corrected by +10 modulo 16. The number of digits is a parameter, and the default of two digits gives the 8-bit byte form. Operands are assumed to hold only legal digits (0 to 9).

Top module: `bcd_addsub_unit`

## Requirements
- R1: In add mode (`sub_mode`=0) `result` is the low `DIGITS` decimal digits of opa + opb + cin, each digit packed in its own nibble, with the least significant digit in bits [3:0].
- R2: In add mode `cout` is 1 exactly when the decimal sum opa + opb + cin reaches 10^DIGITS.
- R3: In subtract mode (`sub_mode`=1), with `opb` carrying the bitwise inverse of the packed subtrahend y, `result` is the packed decimal value of opa − y − (1 − cin), taken modulo 10^DIGITS.
- R4: In subtract mode `cout` is 1 when opa − y − (1 − cin) ≥ 0 (no borrow) and 0 when a borrow occurs.
- R5: `ovf` equals `cout` after an add and equals the inverse of `cout` after a subtract.
- R6: `done` is high for exactly the one cycle that follows the clock edge at which `start` is sampled high with `rst` low. The new `result`, `cout` and `ovf` are visible in that same cycle.
- R7: While `rst` is high, at every clock edge `result`, `cout`, `ovf` and `done` are cleared to 0.
- R8: A `start` that is sampled while `rst` is high is ignored: it produces no `done` pulse and no result.
- R9: When `start` is low, `result`, `cout` and `ovf` keep their values across clock edges, whatever the operand, mode and carry inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request strobe |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| opa | input | 4*DIGITS | First packed-decimal operand |
| opb | input | 4*DIGITS | Second operand; bit-inverted subtrahend when subtracting |
| cin | input | 1 | Carry-in; means "no borrow" when subtracting |
| result | output | 4*DIGITS | Registered packed-decimal result |
| cout | output | 1 | Registered decimal carry-out |
| ovf | output | 1 | Registered overflow flag |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench builds the unit with the default `DIGITS`=2. At that size every legal operand pair (100 × 100) can be swept with both carry-in values in both modes, so each digit's +6 and +10 corrections are exercised. So is every carry and borrow that passes from the low digit into the high digit, and every wrap at 99/00. Directed sequences then check the length of the `done` pulse, a strobe held off by reset, and that the outputs hold while the inputs change without a strobe.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int NIB_W = 4;

    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } bcd_mode_e;
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import bcd_pkg::*;
(
    input  logic             sub_mode,
    input  logic [NIB_W-1:0] a_nib,
    input  logic [NIB_W-1:0] b_nib,
    input  logic             c_in,
    output logic [NIB_W-1:0] digit,
    output logic             c_out
);
    logic [NIB_W:0] raw_sum;
    logic           over_nine;

    always_comb begin
        raw_sum   = {1'b0, a_nib} + {1'b0, b_nib} + {{NIB_W{1'b0}}, c_in};
        // bit3 with bit2 or bit1 set means the low four bits exceed nine
        over_nine = raw_sum[3] & (raw_sum[2] | raw_sum[1]);
        if (bcd_mode_e'(sub_mode) == MODE_SUB) begin
            c_out = raw_sum[NIB_W] & ~over_nine;
            digit = c_out ? raw_sum[NIB_W-1:0] : raw_sum[NIB_W-1:0] + 4'd10;
        end else begin
            c_out = raw_sum[NIB_W] | over_nine;
            digit = c_out ? raw_sum[NIB_W-1:0] + 4'd6 : raw_sum[NIB_W-1:0];
        end
    end
endmodule

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain
    import bcd_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W = NIB_W * DIGITS
) (
    input  logic         sub_mode,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         carry
);
    logic [DIGITS:0] link;

    assign link[0] = cin;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bcd_digit_cell u_cell (
            .sub_mode (sub_mode),
            .a_nib    (opa[g*NIB_W +: NIB_W]),
            .b_nib    (opb[g*NIB_W +: NIB_W]),
            .c_in     (link[g]),
            .digit    (sum[g*NIB_W +: NIB_W]),
            .c_out    (link[g+1])
        );
    end

    assign carry = link[DIGITS];
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
    import bcd_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W = NIB_W * DIGITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         sub_mode,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         cin,
    output logic [W-1:0] result,
    output logic         cout,
    output logic         ovf,
    output logic         done
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         co;
        logic         ov;
        logic         vld;
    } out_state_t;

    out_state_t   st_d, st_q;
    logic [W-1:0] chain_sum;
    logic         chain_carry;

    bcd_digit_chain #(.DIGITS(DIGITS)) u_chain (
        .sub_mode (sub_mode),
        .opa      (opa),
        .opb      (opb),
        .cin      (cin),
        .sum      (chain_sum),
        .carry    (chain_carry)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (start) begin
            st_d.res = chain_sum;
            st_d.co  = chain_carry;
            st_d.ov  = (bcd_mode_e'(sub_mode) == MODE_SUB) ? ~chain_carry : chain_carry;
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign result = st_q.res;
    assign cout   = st_q.co;
    assign ovf    = st_q.ov;
    assign done   = st_q.vld;
endmodule

// File: rtl/bcd_addsub_checker.sv
module bcd_addsub_checker
    import bcd_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W = NIB_W * DIGITS
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         sub_mode,
    input logic [W-1:0] result,
    input logic         cout,
    input logic         ovf,
    input logic         done
);
    function automatic logic digits_legal(input logic [W-1:0] v);
        logic ok = 1'b1;
        for (int i = 0; i < DIGITS; i++)
            if (v[i*NIB_W +: NIB_W] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    AST_DIGITS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> digits_legal(result)); // R1

    AST_OVF_TRACKS_CARRY: assert property (@(posedge clk) disable iff (rst)
        done |-> (ovf == (cout ^ $past(sub_mode)))); // R5

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done); // R6

    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start && !rst)); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!done && result == '0 && !cout && !ovf)); // R7

    AST_RESET_BLOCKS_START: assert property (@(posedge clk)
        (rst && start) |=> !done); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(start) && !$past(rst)) |-> $stable({result, cout, ovf})); // R9
endmodule

bind bcd_addsub_unit bcd_addsub_checker #(.DIGITS(DIGITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sub_mode (sub_mode),
    .result   (result),
    .cout     (cout),
    .ovf      (ovf),
    .done     (done)
);

// File: tb/tb_bcd_addsub_unit.sv
module tb_bcd_addsub_unit;
    localparam int DIGITS = 2;
    localparam int W = 4 * DIGITS;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         sub_mode = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         cin = 1'b0;
    logic [W-1:0] result;
    logic         cout, ovf, done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bcd_addsub_unit #(.DIGITS(DIGITS)) dut (
        .clk(clk), .rst(rst), .start(start), .sub_mode(sub_mode),
        .opa(opa), .opb(opb), .cin(cin),
        .result(result), .cout(cout), .ovf(ovf), .done(done)
    );

    function automatic logic [W-1:0] to_bcd(input int v);
        return W'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one request; samples in the cycle after the strobe edge
    task automatic run_op(input bit sub, input int x, input int y, input bit c);
        int val, er, ec;
        @(negedge clk);
        sub_mode = sub;
        opa = to_bcd(x);
        opb = sub ? ~to_bcd(y) : to_bcd(y);
        cin = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (sub) begin
            val = x - y - (c ? 0 : 1);
            ec  = (val >= 0) ? 1 : 0;
            er  = (val < 0) ? val + 100 : val;
            chk("R3 sub result", int'(result), int'(to_bcd(er)));
            chk("R4 sub carry", int'(cout), ec);
            chk("R5 sub ovf", int'(ovf), 1 - ec);
        end else begin
            val = x + y + (c ? 1 : 0);
            ec  = (val >= 100) ? 1 : 0;
            er  = val % 100;
            chk("R1 add result", int'(result), int'(to_bcd(er)));
            chk("R2 add carry", int'(cout), ec);
            chk("R5 add ovf", int'(ovf), ec);
        end
        chk("R6 done high", int'(done), 1);
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        // R7 and R8: strobe during reset, outputs stay cleared
        repeat (3) @(negedge clk);
        sub_mode = 1'b0; opa = to_bcd(99); opb = to_bcd(99); cin = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 reset result", int'(result), 0);
        chk("R7 reset carry", int'(cout), 0);
        chk("R7 reset ovf", int'(ovf), 0);
        chk("R8 no done in reset", int'(done), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 no late done", int'(done), 0);
        chk("R8 no late result", int'(result), 0);

        // R6: pulse length
        run_op(1'b0, 45, 38, 1'b0);
        @(negedge clk);
        chk("R6 done single cycle", int'(done), 0);

        // R9: inputs change with no strobe
        run_op(1'b1, 10, 27, 1'b1);
        held = result;
        @(negedge clk);
        sub_mode = 1'b0; opa = to_bcd(77); opb = to_bcd(66); cin = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 result held", int'(result), int'(held));
        chk("R9 carry held", int'(cout), 0);
        chk("R9 ovf held", int'(ovf), 1);
        chk("R9 no done", int'(done), 0);

        // boundary wraps
        run_op(1'b0, 99, 99, 1'b1);
        run_op(1'b0, 0, 0, 1'b0);
        run_op(1'b1, 0, 0, 1'b0);
        run_op(1'b1, 0, 99, 1'b1);

        // exhaustive sweep
        for (int s = 0; s < 2; s++)
            for (int x = 0; x < 100; x++)
                for (int y = 0; y < 100; y++)
                    for (int c = 0; c < 2; c++)
                        run_op(s[0], x, y, c[0]);

        // R7: reset after activity clears outputs
        run_op(1'b0, 99, 1, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R7 clear after use", int'(result), 0);
        chk("R7 carry cleared", int'(cout), 0);
        rst = 1'b0;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule